// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from memory. A caller presents a virtual address together with the base of the first-level translation table. The walker reads one first-level descriptor. That descriptor either maps a 1 MB section directly or points to a second-level table. A second-level descriptor maps either a 64 KB large page or a 4 KB small page. Bits that lie inside the mapped region pass through unchanged and are placed after the physical region bits taken from the descriptor.

Memory is read one 32-bit word at a time over a request/response port. The memory may take any number of cycles to answer. Each walk ends with a one-cycle result that carries either a physical address or a fault. The walker takes a new request only when it is idle. There is no translation cache, no permission checking beyond the fault outcome, and no replacement logic.

Top module: `xlat_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready`=1, `mem_req`=0, `resp_valid`=0.
- R2: When a request is accepted, the first memory read is at address {`tbl_base`[31:14], `req_vaddr`[31:20], 2'b00}. The base is sampled in the accept cycle, and `mem_req` rises in the cycle after that.
- R3: A first-level descriptor D1 with D1[1:0]=2'b10 maps a section. The result is `resp_paddr`={D1[31:20], va[19:0]} with `resp_fault`=0, and the walk performs exactly one memory read.
- R4: A first-level descriptor D1 with D1[1:0]=2'b01 points to a second-level table. The walker then performs a second read at {D1[31:10], va[19:12], 2'b00}.
- R5: A second-level descriptor D2 with D2[1:0]=2'b01 maps a large page. The result is `resp_paddr`={D2[31:16], va[15:0]}.
- R6: A second-level descriptor D2 with D2[1:0]=2'b10 maps a small page. The result is `resp_paddr`={D2[31:12], va[11:0]}.
- R7: A descriptor type of 2'b00 or 2'b11 at either level ends the walk with `resp_fault`=1 and `resp_paddr`=0. A first-level fault performs no second read.
- R8: While `mem_req` is high and `mem_rvalid` is low, `mem_req` stays high and `mem_addr` stays stable. The walker waits for any number of cycles.
- R9: `req_ready` is 1 only when idle. `req_valid` while busy is ignored: it neither changes the result in progress nor starts a later walk.
- R10: `resp_valid` is a single-cycle pulse in the cycle after the `mem_rvalid` that completes the walk. `mem_req` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | First-level table base (bits 31:14 used) |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| mem_req | output | 1 | Memory word read request, held until answered |
| mem_addr | output | 32 | Byte address of the descriptor word |
| mem_rvalid | input | 1 | Read data valid, completes the pending read |
| mem_rdata | input | 32 | Descriptor word read |
| resp_valid | output | 1 | Walk result valid for one cycle |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_paddr | output | 32 | Physical address, zero on fault |

## Verification
The bench's memory model answers after a random delay, including a delay of zero. This exposes a walker that samples read data early or moves `mem_addr` while a read is pending. Random descriptor types at both levels, including the reserved code 2'b11, would catch two errors: a swapped large/small split, which takes offset bits from the wrong boundary, and a first-level fault that still issues a second read. Requests are raised on purpose while a walk is running. A walker that accepts them would corrupt the latched address or start an extra walk after the result pulse.

// File: rtl/xw_pkg.sv
// Shared types for the translation walker.
// Assumes: descriptor type codes occupy bits 1:0 at both levels.
package xw_pkg;
    // Outcome of decoding one descriptor word
    typedef enum logic [1:0] {
        DK_FAULT = 2'd0,
        DK_NEXT  = 2'd1,
        DK_LEAF  = 2'd2
    } dkind_t;

    // Walk controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT1 = 2'd1,
        ST_WAIT2 = 2'd2,
        ST_DONE  = 2'd3
    } wstate_t;
endpackage

// File: rtl/xw_desc_decode.sv
// Combinational decode of one descriptor word for a given table level.
// LEVEL=1: 01 -> next-level table, 10 -> section; LEVEL=2: 01 -> large page,
// 10 -> small page. Codes 00 and 11 are faults at both levels.
// Assumes: vaddr is the latched virtual address of the walk in progress.
module xw_desc_decode
    import xw_pkg::*;
#(
    parameter int LEVEL    = 1,
    parameter int ADDR_W   = 32,
    parameter int L2_IDX_W = 8,
    parameter int PAGE_W   = 12,
    parameter int LARGE_W  = 16,
    parameter int SECT_W   = 20
) (
    input  logic [ADDR_W-1:0] desc,
    input  logic [ADDR_W-1:0] vaddr,
    output dkind_t            kind,
    output logic [ADDR_W-1:0] paddr,
    output logic [ADDR_W-1:0] next_addr
);
    localparam int L2TBL_W = L2_IDX_W + 2;

    generate
        if (LEVEL == 1) begin : g_first
            // First-level decode: section leaf or pointer to second level
            always_comb begin
                kind      = DK_FAULT;
                paddr     = '0;
                next_addr = {desc[ADDR_W-1:L2TBL_W], vaddr[SECT_W-1:PAGE_W], 2'b00};
                case (desc[1:0])
                    2'b10: begin
                        kind  = DK_LEAF;
                        paddr = {desc[ADDR_W-1:SECT_W], vaddr[SECT_W-1:0]};
                    end
                    2'b01: kind = DK_NEXT;
                    default: kind = DK_FAULT;
                endcase
            end
        end else begin : g_second
            // Second-level decode: large or small page leaf
            always_comb begin
                kind      = DK_FAULT;
                paddr     = '0;
                next_addr = '0;
                case (desc[1:0])
                    2'b01: begin
                        kind  = DK_LEAF;
                        paddr = {desc[ADDR_W-1:LARGE_W], vaddr[LARGE_W-1:0]};
                    end
                    2'b10: begin
                        kind  = DK_LEAF;
                        paddr = {desc[ADDR_W-1:PAGE_W], vaddr[PAGE_W-1:0]};
                    end
                    default: kind = DK_FAULT;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/xw_walk_ctrl.sv
// Walk sequencer: accepts a request when idle, issues the first-level read,
// optionally the second-level read, and registers the result for one cycle.
// Assumes: memory answers each held request with one mem_rvalid pulse.
module xw_walk_ctrl
    import xw_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int L1_IDX_W = 12,
    parameter int SECT_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] tbl_base,
    output logic              req_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    output logic [ADDR_W-1:0] va_q,
    input  dkind_t            l1_kind,
    input  logic [ADDR_W-1:0] l1_paddr,
    input  logic [ADDR_W-1:0] l1_next,
    input  dkind_t            l2_kind,
    input  logic [ADDR_W-1:0] l2_paddr,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [ADDR_W-1:0] resp_paddr
);
    localparam int TBL_LOW = L1_IDX_W + 2;

    wstate_t state;

    assign req_ready  = (state == ST_IDLE);
    assign mem_req    = (state == ST_WAIT1) || (state == ST_WAIT2);
    assign resp_valid = (state == ST_DONE);

    // Advance the walk and capture address, read target and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            va_q       <= '0;
            mem_addr   <= '0;
            resp_fault <= 1'b0;
            resp_paddr <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    va_q     <= req_vaddr;
                    mem_addr <= {tbl_base[ADDR_W-1:TBL_LOW], req_vaddr[ADDR_W-1:SECT_W], 2'b00};
                    state    <= ST_WAIT1;
                end
                ST_WAIT1: if (mem_rvalid) begin
                    case (l1_kind)
                        DK_NEXT: begin
                            mem_addr <= l1_next;
                            state    <= ST_WAIT2;
                        end
                        DK_LEAF: begin
                            resp_fault <= 1'b0;
                            resp_paddr <= l1_paddr;
                            state      <= ST_DONE;
                        end
                        default: begin
                            resp_fault <= 1'b1;
                            resp_paddr <= '0;
                            state      <= ST_DONE;
                        end
                    endcase
                end
                ST_WAIT2: if (mem_rvalid) begin
                    resp_fault <= (l2_kind != DK_LEAF);
                    resp_paddr <= (l2_kind == DK_LEAF) ? l2_paddr : '0;
                    state      <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xlat_walker.sv
// Two-level translation walker top: joins the sequencer with one descriptor
// decoder per table level. Both decoders see the raw read data; the
// sequencer uses the one that matches the level being read.
// Assumes: tbl_base is aligned to the first-level table size.
module xlat_walker
    import xw_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int L1_IDX_W = 12,
    parameter int L2_IDX_W = 8,
    parameter int PAGE_W   = 12,
    parameter int LARGE_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] tbl_base,
    output logic              req_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [ADDR_W-1:0] resp_paddr
);
    localparam int SECT_W = ADDR_W - L1_IDX_W;

    logic [ADDR_W-1:0] va_q;
    dkind_t            l1_kind, l2_kind;
    logic [ADDR_W-1:0] l1_paddr, l1_next, l2_paddr, l2_next;

    xw_desc_decode #(.LEVEL(1), .ADDR_W(ADDR_W), .L2_IDX_W(L2_IDX_W),
                     .PAGE_W(PAGE_W), .LARGE_W(LARGE_W), .SECT_W(SECT_W))
    i_dec1 (.desc(mem_rdata), .vaddr(va_q), .kind(l1_kind),
            .paddr(l1_paddr), .next_addr(l1_next));

    xw_desc_decode #(.LEVEL(2), .ADDR_W(ADDR_W), .L2_IDX_W(L2_IDX_W),
                     .PAGE_W(PAGE_W), .LARGE_W(LARGE_W), .SECT_W(SECT_W))
    i_dec2 (.desc(mem_rdata), .vaddr(va_q), .kind(l2_kind),
            .paddr(l2_paddr), .next_addr(l2_next));

    xw_walk_ctrl #(.ADDR_W(ADDR_W), .L1_IDX_W(L1_IDX_W), .SECT_W(SECT_W))
    i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .tbl_base(tbl_base),
        .req_ready(req_ready), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .va_q(va_q),
        .l1_kind(l1_kind), .l1_paddr(l1_paddr), .l1_next(l1_next),
        .l2_kind(l2_kind), .l2_paddr(l2_paddr),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr)
    );
endmodule

// File: rtl/xw_checker.sv
// Protocol checks on the walker ports, bound to every xlat_walker instance.
// Assumes: synchronous active-low reset; checks are off while it is low.
module xw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic [31:0] tbl_base,
    input logic        req_ready,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_rvalid,
    input logic        resp_valid,
    input logic        resp_fault,
    input logic [31:0] resp_paddr
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R8

    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=>
            (mem_req && mem_addr == {$past(tbl_base[31:14]), $past(req_vaddr[31:20]), 2'b00})); // R2

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R10

    AST_RESP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !mem_req); // R10

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready); // R9

    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_paddr == 32'd0)); // R7
endmodule

bind xlat_walker xw_checker i_xw_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .tbl_base(tbl_base), .req_ready(req_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .resp_valid(resp_valid),
    .resp_fault(resp_fault), .resp_paddr(resp_paddr)
);

// File: tb/test_xlat_walker.sv
// Bench: random and directed walks against a delaying memory model.
module test_xlat_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] tbl_base = '0;
    logic        req_ready, mem_req, resp_valid, resp_fault;
    logic [31:0] mem_addr, resp_paddr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int errors = 0;
    int checks = 0;
    longint cycles = 0;

    // stimulus descriptors and memory model state
    logic [31:0] cur_d1, cur_d2, exp_a1, exp_a2, held_addr;
    int reads = 0;
    int addr_bad = 0;
    bit pending = 0;
    int delay = 0;

    xlat_walker i_xlat_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .tbl_base(tbl_base), .req_ready(req_ready), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: answers each held request after 0..3 cycles
    always @(negedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid <= 1'b0;
            pending    <= 1'b0;
        end else if (mem_req && rst_n) begin
            if (!pending) begin
                pending   = 1'b1;
                delay     = int'($urandom % 4);
                held_addr = mem_addr;
                if (reads == 0 && mem_addr != exp_a1) addr_bad++;
                if (reads == 1 && mem_addr != exp_a2) addr_bad++;
                mem_rdata <= (reads == 0) ? cur_d1 : cur_d2;
                reads++;
            end else if (mem_addr != held_addr) begin
                addr_bad++;
            end
            if (delay == 0) mem_rvalid <= 1'b1;
            else delay--;
        end
    end

    // reference walk computed from the requirement encodings
    function automatic void ref_walk(input logic [31:0] va, input logic [31:0] tb,
                                     input logic [31:0] d1, input logic [31:0] d2,
                                     output bit flt, output logic [31:0] pa,
                                     output int nrd, output logic [31:0] a1,
                                     output logic [31:0] a2);
        a1 = {tb[31:14], va[31:20], 2'b00};
        a2 = {d1[31:10], va[19:12], 2'b00};
        flt = 1'b1; pa = '0; nrd = 1;
        if (d1[1:0] == 2'b10) begin
            flt = 1'b0; pa = {d1[31:20], va[19:0]};
        end else if (d1[1:0] == 2'b01) begin
            nrd = 2;
            if (d2[1:0] == 2'b01) begin flt = 1'b0; pa = {d2[31:16], va[15:0]}; end
            else if (d2[1:0] == 2'b10) begin flt = 1'b0; pa = {d2[31:12], va[11:0]}; end
        end
    endfunction

    task automatic walk(input logic [31:0] va, input logic [31:0] tb,
                        input logic [31:0] d1, input logic [31:0] d2, input bit poke);
        bit flt; logic [31:0] pa; int nrd; int wait_n; string tag;
        ref_walk(va, tb, d1, d2, flt, pa, nrd, exp_a1, exp_a2);
        cur_d1 = d1; cur_d2 = d2; reads = 0; addr_bad = 0;
        tag = (d1[1:0] == 2'b10) ? "R3" : (d1[1:0] != 2'b01) ? "R7" :
              (d2[1:0] == 2'b01) ? "R5" : (d2[1:0] == 2'b10) ? "R6" : "R7";
        @(negedge clk);
        check(req_ready === 1'b1, "R9 ready when idle", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_vaddr = va; tbl_base = tb;
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = ~va; tbl_base = ~tb;
        wait_n = 0;
        while (resp_valid !== 1'b1 && wait_n < 100) begin
            if (poke) begin
                req_valid = mem_req;
                if (mem_req) check(req_ready === 1'b0, "R9 not ready while busy", {31'd0, req_ready}, 32'd0);
            end
            @(negedge clk);
            wait_n++;
        end
        req_valid = 1'b0;
        check(resp_valid === 1'b1, "R10 result pulse seen", {31'd0, resp_valid}, 32'd1);
        check(resp_fault === flt, {tag, " fault flag"}, {31'd0, resp_fault}, {31'd0, flt});
        check(resp_paddr === pa, {tag, " physical address"}, resp_paddr, pa);
        check(reads == nrd, (nrd == 2) ? "R4 read count" : "R7/R3 read count one", reads, nrd);
        check(addr_bad == 0, "R2 R4 R8 read address", addr_bad, 0);
        check(mem_req === 1'b0, "R10 no read with result", {31'd0, mem_req}, 32'd0);
        @(negedge clk);
        check(resp_valid === 1'b0, "R10 single-cycle pulse", {31'd0, resp_valid}, 32'd0);
        if (poke) begin
            @(negedge clk);
            check(mem_req === 1'b0 && req_ready === 1'b1, "R9 busy request not queued",
                  {31'd0, mem_req}, 32'd0);
        end
    endtask

    function automatic logic [31:0] rdesc();
        return $urandom & 32'hFFFF_FFFC | ($urandom % 4);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready === 1'b1 && mem_req === 1'b0 && resp_valid === 1'b0,
              "R1 idle after reset", {29'd0, req_ready, mem_req, resp_valid}, 32'd4);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_req === 1'b0, "R1 no read without request", {31'd0, mem_req}, 32'd0);
        // directed corner cases
        walk(32'hABC1_2345, 32'h8000_4000, 32'h3FF0_0002, 32'h0, 0);          // R3 section
        walk(32'hFFFF_FFFF, 32'hFFFF_C000, 32'h1234_5401, 32'hCAFE_0001, 0);  // R5 large page
        walk(32'h0012_3456, 32'h0000_0000, 32'h0000_0401, 32'hBEEF_1002, 0);  // R6 small page
        walk(32'h5000_0000, 32'h1000_0000, 32'h7777_7700, 32'h0, 0);          // R7 L1 fault 00
        walk(32'h6000_0000, 32'h1000_0000, 32'h7777_7703, 32'h0, 0);          // R7 L1 fault 11
        walk(32'h7001_2000, 32'h2000_0000, 32'h3333_3001, 32'h4444_4003, 0);  // R7 L2 fault 11
        walk(32'h7001_2000, 32'h2000_0000, 32'h3333_3001, 32'h4444_4000, 1);  // R9 busy poke
        walk(32'h0100_0000, 32'h4000_0000, 32'h0550_0002, 32'h0, 1);          // R9 poke on section
        // constrained random walks
        for (int i = 0; i < 300; i++)
            walk($urandom, $urandom, rdesc(), rdesc(), ($urandom % 5) == 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    initial begin
        wait (cycles > 150000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule